// File: doc/BRIEF.md
# Per-Core Banked Timer and Watchdog Access Router

This block sits between a register bus and a bank of counter instances, one timer and one watchdog for each processor core, with between one and four cores. Every access carries the identity of the core that issued it. The block splits the address into a window number and a byte offset within that window. Windows are 32 bytes each. From the window number and the requester identity it picks exactly one instance. It then drives that instance's write or read strobe, passes the offset and write data on to it, and returns that instance's read data in the same cycle.

Two windows at the bottom of the map are aliases. The first reaches the timer of whichever core is asking, and the second reaches that core's watchdog. Software on every core can therefore use one fixed address to reach its own private counters. Each instance also has its own window, so any core can reach any other core's counters directly.

An alias access from a requester identity that is not a configured core, and any access to a window past the last configured core, is refused. A refused access returns an error flag and zero read data, and it strobes no instance. The block also merges the per-core timer and watchdog interrupt lines into one vector ordered by instance number.

Top module: `mpt_core_bank_router`

## Requirements
- R1: An access to window 0 (address bits above bit 4 equal to 0) from requester `k`, where `k` is below NUM_CORES, targets instance `2k`, the timer of core `k`.
- R2: An access to window 1 from requester `k`, where `k` is below NUM_CORES, targets instance `2k+1`, the watchdog of core `k`.
- R3: An access to window `w` with `2 <= w < 2+2*NUM_CORES` targets instance `w-2` whatever the requester identity is. Even instances are timers and odd instances are watchdogs.
- R4: An access to window 0 or 1 from a requester identity of NUM_CORES or above raises `rsp_err`. It strobes no instance and returns zero read data.
- R5: An access to any window at or beyond `2+2*NUM_CORES` raises `rsp_err`. It strobes no instance and returns zero read data.
- R6: At most one strobe bit is high in any cycle. A valid access that is not refused raises exactly one bit: the target's bit in `inst_wr_en` when `req_write` is 1, or the target's bit in `inst_rd_en` when `req_write` is 0.
- R7: In the same cycle as an accepted read, `rsp_rdata` equals the slice of `inst_rdata` at bits `[i*DATA_W +: DATA_W]` for target `i`. During writes, refused accesses and idle cycles it is zero.
- R8: `inst_offset` always equals address bits [4:0], and `inst_wdata` always equals `req_wdata`.
- R9: `irq_out[2c]` follows `tmr_irq[c]` and `irq_out[2c+1]` follows `wdg_irq[c]` for every core `c`.
- R10: While `req_valid` is 0, no strobe is raised, `rsp_err` is 0 and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the built-in checks |
| rst_n | input | 1 | Active-low reset, used to gate the built-in checks |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address: window number above bit 4, offset in bits [4:0] |
| req_wdata | input | DATA_W | Write data |
| req_id | input | REQ_ID_W | Identity of the issuing core |
| rsp_rdata | output | DATA_W | Read data from the selected instance, or zero |
| rsp_err | output | 1 | Access refused |
| inst_wr_en | output | 2*NUM_CORES | One-hot write strobe per instance |
| inst_rd_en | output | 2*NUM_CORES | One-hot read strobe per instance |
| inst_offset | output | 5 | Byte offset within the instance window |
| inst_wdata | output | DATA_W | Write data forwarded to the instances |
| inst_rdata | input | 2*NUM_CORES*DATA_W | Read data of all instances, instance i at bits [i*DATA_W +: DATA_W] |
| tmr_irq | input | NUM_CORES | Timer interrupt of each core |
| wdg_irq | input | NUM_CORES | Watchdog interrupt of each core |
| irq_out | output | 2*NUM_CORES | Interrupts ordered by instance number |

## Verification
The hardest case to reach from the ports is a requester identity that names no configured core, because the identity field is always at least as wide as the core count needs. With four cores and a 2-bit identity that case cannot occur at all. The bench therefore builds the router with three cores, so identity 3 is a legal code that is out of range. It then sweeps every identity against every window in the 16-window address space, for both reads and writes. This covers the aliases, the direct windows and the unused windows above them in every combination. Each instance returns read data derived from its own index, so a wrong selection shows up directly in the read data.

// File: rtl/mpt_route_pkg.sv
package mpt_route_pkg;

  // Every instance window spans 32 bytes.
  localparam int unsigned OFFSET_W = 5;

  // Windows below this number are per-requester aliases.
  localparam int unsigned ALIAS_WINDOWS = 2;

  typedef enum logic [1:0] {
    WK_ALIAS_TMR = 2'd0,
    WK_ALIAS_WDG = 2'd1,
    WK_DIRECT    = 2'd2,
    WK_NONE      = 2'd3
  } win_kind_e;

  // Instance number of a core's timer (flavour 0) or watchdog (flavour 1).
  function automatic int unsigned inst_of_core(int unsigned core, int unsigned flavour);
    return core * 2 + flavour;
  endfunction

endpackage

// File: rtl/mpt_win_decode.sv
module mpt_win_decode
  import mpt_route_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned WIN_W     = 4,
  parameter int unsigned REQ_ID_W  = 2,
  parameter int unsigned SEL_W     = 3
) (
  input  logic [WIN_W-1:0]    win_idx,
  input  logic [REQ_ID_W-1:0] req_id,
  output logic                hit,
  output win_kind_e           kind,
  output logic [SEL_W-1:0]    sel
);

  localparam int unsigned NUM_INST = 2 * NUM_CORES;
  localparam int unsigned NUM_WIN  = ALIAS_WINDOWS + NUM_INST;

  logic         id_in_range;
  int unsigned  win_u;
  int unsigned  tgt;

  assign win_u       = 32'(win_idx);
  assign id_in_range = 32'(req_id) < NUM_CORES;

  always_comb begin
    kind = WK_NONE;
    hit  = 1'b0;
    tgt  = 0;
    if (win_u < ALIAS_WINDOWS) begin
      kind = (win_u == 0) ? WK_ALIAS_TMR : WK_ALIAS_WDG;
      hit  = id_in_range;
      tgt  = inst_of_core(32'(req_id), win_u);
    end else if (win_u < NUM_WIN) begin
      kind = WK_DIRECT;
      hit  = 1'b1;
      tgt  = win_u - ALIAS_WINDOWS;
    end
  end

  assign sel = hit ? SEL_W'(tgt) : '0;

endmodule

// File: rtl/mpt_rd_mux.sv
module mpt_rd_mux #(
  parameter int unsigned NUM_INST = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [NUM_INST-1:0]        rd_en,
  input  logic [NUM_INST*DATA_W-1:0] rdata_bus,
  output logic [DATA_W-1:0]          rdata
);

  logic [DATA_W-1:0] acc [NUM_INST+1];

  assign acc[0] = '0;

  // AND-OR chain: a one-hot (or empty) read strobe picks one slice or none.
  for (genvar i = 0; i < NUM_INST; i++) begin : g_or
    assign acc[i+1] = acc[i] | (rd_en[i] ? rdata_bus[i*DATA_W +: DATA_W] : '0);
  end

  assign rdata = acc[NUM_INST];

endmodule

// File: rtl/mpt_irq_order.sv
module mpt_irq_order #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CORES-1:0]   tmr_irq,
  input  logic [NUM_CORES-1:0]   wdg_irq,
  output logic [2*NUM_CORES-1:0] irq_out
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign irq_out[2*c]     = tmr_irq[c];
    assign irq_out[2*c + 1] = wdg_irq[c];
  end

  // R9: the merged vector carries as many active lines as both sources together.
  a_r9_irq_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) == $countones(tmr_irq) + $countones(wdg_irq));

endmodule

// File: rtl/mpt_core_bank_router.sv
module mpt_core_bank_router
  import mpt_route_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REQ_ID_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [REQ_ID_W-1:0]           req_id,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          rsp_err,
  output logic [2*NUM_CORES-1:0]        inst_wr_en,
  output logic [2*NUM_CORES-1:0]        inst_rd_en,
  output logic [4:0]                    inst_offset,
  output logic [DATA_W-1:0]             inst_wdata,
  input  logic [2*NUM_CORES*DATA_W-1:0] inst_rdata,
  input  logic [NUM_CORES-1:0]          tmr_irq,
  input  logic [NUM_CORES-1:0]          wdg_irq,
  output logic [2*NUM_CORES-1:0]        irq_out
);

  localparam int unsigned NUM_INST = 2 * NUM_CORES;
  localparam int unsigned NUM_WIN  = ALIAS_WINDOWS + NUM_INST;
  localparam int unsigned WIN_W    = ADDR_W - OFFSET_W;
  localparam int unsigned SEL_W    = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;

  logic [WIN_W-1:0] win_idx;
  logic             dec_hit;
  win_kind_e        dec_kind;
  logic [SEL_W-1:0] dec_sel;
  logic             acc_ok;
  logic             acc_bad;

  assign win_idx = req_addr[ADDR_W-1:OFFSET_W];

  mpt_win_decode #(
    .NUM_CORES (NUM_CORES),
    .WIN_W     (WIN_W),
    .REQ_ID_W  (REQ_ID_W),
    .SEL_W     (SEL_W)
  ) u_dec (
    .win_idx (win_idx),
    .req_id  (req_id),
    .hit     (dec_hit),
    .kind    (dec_kind),
    .sel     (dec_sel)
  );

  assign acc_ok  = req_valid &&  dec_hit;
  assign acc_bad = req_valid && !dec_hit;

  for (genvar i = 0; i < NUM_INST; i++) begin : g_strobe
    assign inst_wr_en[i] = acc_ok &&  req_write && (32'(dec_sel) == i);
    assign inst_rd_en[i] = acc_ok && !req_write && (32'(dec_sel) == i);
  end

  assign inst_offset = req_addr[OFFSET_W-1:0];
  assign inst_wdata  = req_wdata;
  assign rsp_err     = acc_bad;

  mpt_rd_mux #(
    .NUM_INST (NUM_INST),
    .DATA_W   (DATA_W)
  ) u_mux (
    .rd_en     (inst_rd_en),
    .rdata_bus (inst_rdata),
    .rdata     (rsp_rdata)
  );

  mpt_irq_order #(
    .NUM_CORES (NUM_CORES)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_irq (tmr_irq),
    .wdg_irq (wdg_irq),
    .irq_out (irq_out)
  );

  // R6: never more than one instance strobed.
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inst_wr_en, inst_rd_en}));

  // R6: an accepted access strobes exactly one instance.
  a_r6_accept_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> $countones({inst_wr_en, inst_rd_en}) == 1);

  // R4: alias from an unconfigured requester is refused and touches nothing.
  a_r4_alias_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(win_idx) < ALIAS_WINDOWS && 32'(req_id) >= NUM_CORES)
      |-> (rsp_err && inst_wr_en == '0 && inst_rd_en == '0 && rsp_rdata == '0));

  // R5: windows past the last core are refused.
  a_r5_hole_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(win_idx) >= NUM_WIN)
      |-> (rsp_err && inst_wr_en == '0 && inst_rd_en == '0 && rsp_rdata == '0));

  // R7: writes return no read data.
  a_r7_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> rsp_rdata == '0);

  // R10: idle cycles are quiet.
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_err && inst_wr_en == '0 && inst_rd_en == '0 && rsp_rdata == '0));

  // R3: a direct window is never refused.
  a_r3_direct_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dec_kind == WK_DIRECT) |-> !rsp_err);

endmodule

// File: tb/sim_mpt_core_bank_router.sv
module sim_mpt_core_bank_router;

  localparam int NC  = 3;
  localparam int AW  = 9;
  localparam int DW  = 32;
  localparam int IDW = 2;
  localparam int NI  = 2 * NC;
  localparam int NWIN_SPACE = 1 << (AW - 5);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic [IDW-1:0]    req_id = '0;
  logic [DW-1:0]     rsp_rdata;
  logic              rsp_err;
  logic [NI-1:0]     inst_wr_en;
  logic [NI-1:0]     inst_rd_en;
  logic [4:0]        inst_offset;
  logic [DW-1:0]     inst_wdata;
  logic [NI*DW-1:0]  inst_rdata;
  logic [NC-1:0]     tmr_irq = '0;
  logic [NC-1:0]     wdg_irq = '0;
  logic [NI-1:0]     irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  mpt_core_bank_router #(
    .NUM_CORES (NC),
    .ADDR_W    (AW),
    .DATA_W    (DW),
    .REQ_ID_W  (IDW)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_id      (req_id),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .inst_wr_en  (inst_wr_en),
    .inst_rd_en  (inst_rd_en),
    .inst_offset (inst_offset),
    .inst_wdata  (inst_wdata),
    .inst_rdata  (inst_rdata),
    .tmr_irq     (tmr_irq),
    .wdg_irq     (wdg_irq),
    .irq_out     (irq_out)
  );

  function automatic logic [DW-1:0] inst_value(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) inst_rdata[i*DW +: DW] = inst_value(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R10: quiet after reset with no access
    chk("R10 reset err", 64'(rsp_err), 0);
    chk("R10 reset wr", 64'(inst_wr_en), 0);
    chk("R10 reset rd", 64'(inst_rd_en), 0);
    chk("R10 reset rdata", 64'(rsp_rdata), 0);
    rst_n = 1'b1;

    // Idle sweep: valid low over every window and requester (R10)
    for (int w = 0; w < NWIN_SPACE; w++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_write = w[0];
      req_addr  = AW'(w * 32 + 3);
      req_id    = IDW'(w);
      #1;
      chk("R10 idle err", 64'(rsp_err), 0);
      chk("R10 idle strobes", 64'({inst_wr_en, inst_rd_en}), 0);
      chk("R10 idle rdata", 64'(rsp_rdata), 0);
    end

    // Full sweep of requester x window x direction
    for (int id = 0; id < (1 << IDW); id++) begin
      for (int w = 0; w < NWIN_SPACE; w++) begin
        for (int wr = 0; wr < 2; wr++) begin
          int    off;
          int    tgt;
          bit    err;
          string tag;
          logic [NI-1:0] exp_wr;
          logic [NI-1:0] exp_rd;
          logic [DW-1:0] exp_rd_data;
          off = (w * 7 + id * 3 + wr) % 32;
          tgt = 0;
          if (w == 0) begin
            err = (id >= NC); tgt = 2 * id;     tag = err ? "R4" : "R1";
          end else if (w == 1) begin
            err = (id >= NC); tgt = 2 * id + 1; tag = err ? "R4" : "R2";
          end else if (w < 2 + NI) begin
            err = 1'b0;       tgt = w - 2;      tag = "R3";
          end else begin
            err = 1'b1;                         tag = "R5";
          end
          exp_wr = (!err && wr == 1) ? NI'(1 << tgt) : '0;
          exp_rd = (!err && wr == 0) ? NI'(1 << tgt) : '0;
          exp_rd_data = (!err && wr == 0) ? inst_value(tgt) : '0;

          @(negedge clk);
          req_valid = 1'b1;
          req_write = wr[0];
          req_addr  = AW'(w * 32 + off);
          req_wdata = 32'hC000_0000 ^ 32'(id << 12) ^ 32'(w << 4) ^ 32'(wr);
          req_id    = IDW'(id);
          #1;
          chk({tag, " err"}, 64'(rsp_err), 64'(err));
          chk({tag, " R6 wr_en"}, 64'(inst_wr_en), 64'(exp_wr));
          chk({tag, " R6 rd_en"}, 64'(inst_rd_en), 64'(exp_rd));
          chk({tag, " R7 rdata"}, 64'(rsp_rdata), 64'(exp_rd_data));
          chk("R8 offset", 64'(inst_offset), 64'(off));
          chk("R8 wdata", 64'(inst_wdata), 64'(req_wdata));
        end
      end
    end

    @(negedge clk);
    req_valid = 1'b0;

    // R9: every interrupt combination
    for (int v = 0; v < (1 << (2 * NC)); v++) begin
      logic [NI-1:0] exp_irq;
      @(negedge clk);
      tmr_irq = NC'(v);
      wdg_irq = NC'(v >> NC);
      exp_irq = '0;
      for (int c = 0; c < NC; c++) begin
        exp_irq[2*c]     = tmr_irq[c];
        exp_irq[2*c + 1] = wdg_irq[c];
      end
      #1;
      chk("R9 irq order", 64'(irq_out), 64'(exp_irq));
    end

    @(negedge clk);
    finish_run();
  end

endmodule